// File: doc/BRIEF.md
# Read/Write Request Arbiter with Selectable Policy

This block sits in front of a single downstream memory port and decides, cycle by cycle, whether a pending read request or a pending write request is sent next. Reads and writes arrive on their own valid/ready channels. Each channel feeds its own request queue. One arbiter takes at most one queue head per cycle and places it in a registered issue slot, which drives a valid/ready channel towards the memory.

A two-bit policy input selects how the arbiter resolves a cycle in which both queues hold work. It can give reads strict precedence, give writes strict precedence, or alternate between the two sides. An enable input gates the whole block. While it is low, upstream requests are still accepted but are thrown away, and no new grant is issued. A synchronous software-clear input empties both queues and the issue slot and restores the alternation state. Each queue has its own almost-full output, set against a programmable occupancy threshold. A busy output reports whether any request is held anywhere in the block.

Top module: `rw_arbiter`

## Requirements
- R1: With `mode` = 2'b10, when both queues are non-empty at a decision, the read head is granted.
- R2: With `mode` = 2'b01, when both queues are non-empty at a decision, the write head is granted.
- R3: With `mode` = 2'b00 or 2'b11, a decision with both queues non-empty grants the side that did not receive the most recent grant. After any reset or software clear, the first such decision goes to the read side.
- R4: When only one queue is non-empty at a decision, that queue is granted, whatever the mode.
- R5: While `enable` is 0, `rd_ready` and `wr_ready` are 1, handshaked requests are discarded, and no new request reaches the issue slot. A request already in the issue slot still completes. Requests already queued are kept and are issued once `enable` returns to 1.
- R6: `rd_afull` (or `wr_afull`) is 1 in every cycle in which that queue's occupancy is greater than or equal to `watermark`. While `enable` is 1, the matching ready is the inverse of that flag. The queue depth is 32.
- R7: `busy` is 1 exactly when either queue is non-empty or `dn_valid` is 1.
- R8: One cycle of `sw_rst` empties both queues and the issue slot, so `busy` and `dn_valid` are 0 afterwards and nothing queued before the clear is ever issued.
- R9: Requests from the same side are issued in the order they were accepted. Write address and data travel together.
- R10: At most one request is loaded into the issue slot per cycle. While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid`, `dn_write`, `dn_addr` and `dn_data` hold.
- R11: A change of `mode` applies from the next decision onward and does not disturb a request already in the issue slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Synchronous software clear of all queued and issued state |
| enable | input | 1 | 1 = normal operation; 0 = accept and discard requests, issue nothing new |
| mode | input | 2 | Arbitration policy: 10 read first, 01 write first, 00/11 alternate |
| watermark | input | 5 | Occupancy at or above which a queue reports almost-full |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | ADDR_W | Read address |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| dn_valid | output | 1 | Issue slot holds a request for the memory port |
| dn_ready | input | 1 | Memory port takes the issued request |
| dn_write | output | 1 | 1 = issued request is a write |
| dn_addr | output | ADDR_W | Issued address |
| dn_data | output | DATA_W | Issued write data (0 for reads) |
| rd_afull | output | 1 | Read queue occupancy at or above watermark |
| wr_afull | output | 1 | Write queue occupancy at or above watermark |
| busy | output | 1 | Any request held in a queue or in the issue slot |

## Verification
A corrupted alternation bit or a wrong policy decode shows up at the first decision after the memory port is released. In that cycle the issue channel presents an address from the wrong side, so the issued-address sequence diverges from the computed order within one cycle. A pointer or occupancy error in a queue shows up as a wrong count of upstream handshakes before the almost-full flag rises. It can also show up as an out-of-order or duplicated address on the issue channel, a few cycles after the queue wraps or fills. A software clear or disable that leaks state shows up as a stray `dn_valid` or a stuck `busy` in the cycles that follow.

// File: rtl/rwa_pkg.sv
package rwa_pkg;

  typedef enum logic [1:0] {
    POL_ALTERNATE = 2'd0,
    POL_RD_FIRST  = 2'd1,
    POL_WR_FIRST  = 2'd2
  } policy_e;

  // 10 -> reads first, 01 -> writes first, 00/11 -> alternate
  function automatic policy_e decode_mode(input logic [1:0] m);
    case (m)
      2'b10:   return POL_RD_FIRST;
      2'b01:   return POL_WR_FIRST;
      default: return POL_ALTERNATE;
    endcase
  endfunction

endpackage

// File: rtl/rwa_fifo.sv
module rwa_fifo #(
  parameter  int W     = 16,
  parameter  int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;

  initial assert (DEPTH == (1 << PTR_W))
    else $error("rwa_fifo: DEPTH must be a power of two");

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign dout  = mem[rptr];
  assign empty = (count == '0);

  // R6: the queue never holds more than its depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push && !pop |-> count < CNT_W'(DEPTH));

  // R9: a head is only taken from a queue that has one
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/rwa_pick.sv
module rwa_pick (
  input  logic             clk,
  input  logic             rst,
  input  rwa_pkg::policy_e policy,
  input  logic             rd_req,
  input  logic             wr_req,
  input  logic             go,
  output logic             gnt_rd,
  output logic             gnt_wr
);
  import rwa_pkg::*;

  // 1 when the most recent grant went to the write side
  logic last_wr;

  always_comb begin
    gnt_rd = 1'b0;
    gnt_wr = 1'b0;
    if (go) begin
      if (rd_req && wr_req) begin
        case (policy)
          POL_RD_FIRST: gnt_rd = 1'b1;
          POL_WR_FIRST: gnt_wr = 1'b1;
          default: begin
            if (last_wr) gnt_rd = 1'b1;
            else         gnt_wr = 1'b1;
          end
        endcase
      end else begin
        gnt_rd = rd_req;
        gnt_wr = wr_req;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  last_wr <= 1'b1;
    else if (gnt_rd || gnt_wr) last_wr <= gnt_wr;
  end

  // R10: at most one grant per cycle
  a_r10_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_rd, gnt_wr}));

  // R4: a lone requester is always served when a decision is made
  a_r4_lone_served: assert property (@(posedge clk) disable iff (rst)
    go && (rd_req != wr_req) |-> (gnt_rd == rd_req) && (gnt_wr == wr_req));

  // R3: alternation never serves the same side twice while both wait
  a_r3_no_repeat: assert property (@(posedge clk) disable iff (rst)
    gnt_wr && policy == POL_ALTERNATE ##1
      (go && rd_req && wr_req && policy == POL_ALTERNATE) |-> gnt_rd);

endmodule

// File: rtl/rwa_issue.sv
module rwa_issue #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              ld_write,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              dn_ready,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic              slot_free
);

  assign slot_free = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_write <= 1'b0;
      dn_addr  <= '0;
      dn_data  <= '0;
    end else if (slot_free) begin
      dn_valid <= load;
      if (load) begin
        dn_write <= ld_write;
        dn_addr  <= ld_addr;
        dn_data  <= ld_data;
      end
    end
  end

  // R10: a stalled issue slot keeps its contents
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_write)
                              && $stable(dn_addr) && $stable(dn_data));

  // R10: nothing is loaded over a stalled request
  a_r10_load_needs_slot: assert property (@(posedge clk) disable iff (rst)
    load |-> slot_free);

endmodule

// File: rtl/rw_arbiter.sv
module rw_arbiter
  import rwa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int WM_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [WM_W-1:0]   watermark,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic              rd_afull,
  output logic              wr_afull,
  output logic              busy
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WR_W  = ADDR_W + DATA_W;

  logic              clr_all;
  logic              rd_push, wr_push;
  logic              gnt_rd, gnt_wr;
  logic              rd_empty, wr_empty;
  logic [CNT_W-1:0]  rd_count, wr_count;
  logic [ADDR_W-1:0] rd_head;
  logic [WR_W-1:0]   wr_head;
  logic              slot_free;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  policy_e           policy;

  assign clr_all = rst || sw_rst;
  assign policy  = decode_mode(mode);

  // occupancy threshold, re-evaluated every cycle
  assign rd_afull = rd_count >= CNT_W'(watermark);
  assign wr_afull = wr_count >= CNT_W'(watermark);

  // while disabled everything is taken and dropped
  assign rd_ready = enable ? !rd_afull : 1'b1;
  assign wr_ready = enable ? !wr_afull : 1'b1;
  assign rd_push  = enable && rd_valid && !rd_afull;
  assign wr_push  = enable && wr_valid && !wr_afull;

  rwa_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) rd_q (
    .clk   (clk),
    .rst   (clr_all),
    .push  (rd_push),
    .din   (rd_addr),
    .pop   (gnt_rd),
    .dout  (rd_head),
    .count (rd_count),
    .empty (rd_empty)
  );

  rwa_fifo #(.W(WR_W), .DEPTH(DEPTH)) wr_q (
    .clk   (clk),
    .rst   (clr_all),
    .push  (wr_push),
    .din   ({wr_addr, wr_data}),
    .pop   (gnt_wr),
    .dout  (wr_head),
    .count (wr_count),
    .empty (wr_empty)
  );

  rwa_pick pick_i (
    .clk    (clk),
    .rst    (clr_all),
    .policy (policy),
    .rd_req (!rd_empty),
    .wr_req (!wr_empty),
    .go     (enable && slot_free),
    .gnt_rd (gnt_rd),
    .gnt_wr (gnt_wr)
  );

  assign ld_addr = gnt_wr ? wr_head[WR_W-1 -: ADDR_W] : rd_head;
  assign ld_data = gnt_wr ? wr_head[DATA_W-1:0] : '0;

  rwa_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) issue_i (
    .clk       (clk),
    .rst       (clr_all),
    .load      (gnt_rd || gnt_wr),
    .ld_write  (gnt_wr),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .dn_ready  (dn_ready),
    .dn_valid  (dn_valid),
    .dn_write  (dn_write),
    .dn_addr   (dn_addr),
    .dn_data   (dn_data),
    .slot_free (slot_free)
  );

  assign busy = !rd_empty || !wr_empty || dn_valid;

  // R1: read-first never serves a write while a read waits
  a_r1_read_first: assert property (@(posedge clk) disable iff (clr_all)
    mode == 2'b10 && gnt_wr |-> rd_empty);

  // R2: write-first never serves a read while a write waits
  a_r2_write_first: assert property (@(posedge clk) disable iff (clr_all)
    mode == 2'b01 && gnt_rd |-> wr_empty);

  // R5: no new grant while disabled
  a_r5_no_grant_off: assert property (@(posedge clk) disable iff (clr_all)
    !enable |-> !(gnt_rd || gnt_wr));

  // R8: a software clear leaves the block idle
  a_r8_clear_idle: assert property (@(posedge clk) disable iff (rst)
    $past(sw_rst) |-> !busy && !dn_valid);

endmodule

// File: tb/rw_arbiter_tb_top.sv
`timescale 1ns/1ps
module rw_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_rst = 1'b0;
  logic        enable = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [4:0]  watermark = 5'd31;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [15:0] rd_addr = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic        dn_write;
  logic [15:0] dn_addr;
  logic [31:0] dn_data;
  logic        rd_afull, wr_afull, busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int rd_acc = 0;
  int wr_acc = 0;

  logic [15:0] got_addr[$];
  logic        got_wr[$];
  logic [31:0] got_data[$];

  always #5 clk = ~clk;

  rw_arbiter dut_i (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .enable(enable), .mode(mode),
    .watermark(watermark),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_data(dn_data),
    .rd_afull(rd_afull), .wr_afull(wr_afull), .busy(busy)
  );

  // monitor: samples 2 ns after the falling edge, before the rising edge
  always begin
    @(negedge clk);
    #2;
    if (!rst && !sw_rst) begin
      if (dn_valid && dn_ready) begin
        got_addr.push_back(dn_addr);
        got_wr.push_back(dn_write);
        got_data.push_back(dn_data);
      end
      if (enable && rd_valid && rd_ready) rd_acc++;
      if (enable && wr_valid && wr_ready) wr_acc++;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prep(input logic [1:0] m, input logic [4:0] wm);
    mode      = m;
    watermark = wm;
    enable    = 1'b1;
    dn_ready  = 1'b0;
    sw_rst    = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    got_addr.delete(); got_wr.delete(); got_data.delete();
    rd_acc = 0;
    wr_acc = 0;
  endtask

  task automatic fill(input int n, input bit use_rd, input bit use_wr);
    for (int i = 0; i < n; i++) begin
      rd_valid = use_rd;
      rd_addr  = 16'(16'h100 + i);
      wr_valid = use_wr;
      wr_addr  = 16'(16'h200 + i);
      wr_data  = 32'(32'hD000 + i);
      @(negedge clk);
    end
    rd_valid = 1'b0;
    wr_valid = 1'b0;
  endtask

  // compare observed issue k with (is_write, index)
  task automatic expect_item(input string tag, input int k, input bit is_wr, input int idx);
    if (k >= got_addr.size()) begin
      checks++; errors++;
      $display("FAIL %s item %0d missing actual=none expected=%0h", tag, k,
               is_wr ? 16'h200 + idx : 16'h100 + idx);
    end else begin
      check(tag, 64'(got_addr[k]), is_wr ? 64'(16'h200 + idx) : 64'(16'h100 + idx));
      check(tag, 64'(got_wr[k]), 64'(is_wr));
      check(tag, 64'(got_data[k]), is_wr ? 64'(32'hD000 + idx) : 64'd0);
    end
  endtask

  localparam int N = 4;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state (R7)
    check("R7 reset busy", 64'(busy), 0);
    check("R10 reset dn_valid", 64'(dn_valid), 0);
    check("R6 reset rd_afull", 64'(rd_afull), 0);
    check("R6 reset rd_ready", 64'(rd_ready), 1);

    // R1 R2 R3 R9: full mode sweep with both queues loaded
    for (int m = 0; m < 4; m++) begin
      prep(2'(m), 5'd31);
      fill(N, 1'b1, 1'b1);
      check("R7 busy while loaded", 64'(busy), 1);
      dn_ready = 1'b1;
      repeat (2 * N + 4) @(negedge clk);
      check("R9 issue count", 64'(got_addr.size()), 64'(2 * N));
      check("R7 busy after drain", 64'(busy), 0);
      for (int k = 0; k < 2 * N; k++) begin
        if (m == 2)      expect_item("R1 read first", k, k >= N, (k >= N) ? k - N : k);
        else if (m == 1) expect_item("R2 write first", k, k < N, (k >= N) ? k - N : k);
        else             expect_item("R3 alternate", k, k % 2 == 1, k / 2);
      end
    end

    // R4: only writes pending under read-first
    prep(2'b10, 5'd31);
    fill(N, 1'b0, 1'b1);
    dn_ready = 1'b1;
    repeat (N + 4) @(negedge clk);
    check("R4 lone side count", 64'(got_addr.size()), 64'(N));
    for (int k = 0; k < N; k++) expect_item("R4 lone side", k, 1'b1, k);

    // R11: switch policy while first read sits stalled in the issue slot
    prep(2'b10, 5'd31);
    fill(N, 1'b1, 1'b1);
    mode = 2'b01;
    dn_ready = 1'b1;
    repeat (2 * N + 4) @(negedge clk);
    check("R11 count", 64'(got_addr.size()), 64'(2 * N));
    expect_item("R11 in-flight kept", 0, 1'b0, 0);
    for (int k = 1; k <= N; k++) expect_item("R11 new policy", k, 1'b1, k - 1);
    for (int k = N + 1; k < 2 * N; k++) expect_item("R11 new policy", k, 1'b0, k - N);

    // R5: disabled accepts and drops
    prep(2'b00, 5'd31);
    enable   = 1'b0;
    dn_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      rd_valid = 1'b1; rd_addr = 16'(16'h300 + i);
      wr_valid = 1'b1; wr_addr = 16'(16'h380 + i);
      #1;
      check("R5 rd_ready while off", 64'(rd_ready), 1);
      check("R5 wr_ready while off", 64'(wr_ready), 1);
      @(negedge clk);
    end
    rd_valid = 1'b0; wr_valid = 1'b0;
    check("R5 busy after drop", 64'(busy), 0);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 nothing issued", 64'(got_addr.size()), 0);

    // R5: in-flight completes, queued entries wait for re-enable
    prep(2'b00, 5'd31);
    fill(3, 1'b1, 1'b0);
    enable   = 1'b0;
    dn_ready = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 in-flight only", 64'(got_addr.size()), 1);
    if (got_addr.size() > 0) check("R5 in-flight addr", 64'(got_addr[0]), 64'h100);
    check("R5 queued retained busy", 64'(busy), 1);
    enable = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 resumed count", 64'(got_addr.size()), 3);
    expect_item("R5 resumed", 1, 1'b0, 1);
    expect_item("R5 resumed", 2, 1'b0, 2);
    check("R7 idle after resume", 64'(busy), 0);

    // R6: exhaustive watermark sweep with a stalled port
    for (int wm = 0; wm < 32; wm++) begin
      prep(2'b10, 5'(wm));
      check("R6 afull at empty", 64'(rd_afull), 64'(wm == 0));
      rd_valid = 1'b1; wr_valid = 1'b1;
      rd_addr = 16'h400; wr_addr = 16'h480; wr_data = 32'h0;
      repeat (40) @(negedge clk);
      rd_valid = 1'b0; wr_valid = 1'b0;
      #1;
      check("R6 rd accepted", 64'(rd_acc), (wm == 0) ? 64'd0 : 64'(wm + 1));
      check("R6 wr accepted", 64'(wr_acc), 64'(wm));
      check("R6 rd_afull at mark", 64'(rd_afull), 1);
      check("R6 wr_afull at mark", 64'(wr_afull), 1);
      check("R6 rd_ready low", 64'(rd_ready), 0);
      check("R6 wr_ready low", 64'(wr_ready), 0);
    end

    // R8: software clear of a loaded block
    check("R8 busy before clear", 64'(busy), 1);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    #1;
    check("R8 busy after clear", 64'(busy), 0);
    check("R8 dn_valid after clear", 64'(dn_valid), 0);
    check("R8 rd_afull after clear", 64'(rd_afull), 0);
    got_addr.delete(); got_wr.delete(); got_data.delete();
    dn_ready = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 nothing issued", 64'(got_addr.size()), 0);

    // R3: alternation restarts on the read side after a clear
    prep(2'b11, 5'd31);
    fill(2, 1'b1, 1'b1);
    dn_ready = 1'b1;
    repeat (8) @(negedge clk);
    expect_item("R3 after clear", 0, 1'b0, 0);
    expect_item("R3 after clear", 1, 1'b1, 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule